// File: doc/BRIEF.md
# Synchronous Processor Bus Byte-Register Slave

This block is a memory-mapped slave on a synchronous local bus of the kind a 32-bit embedded processor drives. The bus side has an 8-bit data path, a 5-bit register address, a pair of chip selects of opposite polarity, a read/write line and a transfer-start strobe. The slave answers each single-beat transfer with a one-cycle active-low acknowledge. In the same cycle it drives an active-low burst-inhibit, which tells the master to split any burst into single beats. Bytes written from the bus land in an internal register file. Each accepted write is also presented to user logic as a one-cycle write-enable with its address and data. User logic reads the same file through a separate synchronous read port.

User logic also supplies a level interrupt request, which may change at any time regardless of bus activity. The slave mirrors it onto an active-low interrupt pin. It also shows it in bit 0 of a read-only status byte at the top address, so the processor can poll it. The interrupt is cleared only by user logic dropping its request.

Top module: `sbus_slave`

## Requirements
- R1: A transfer is accepted only when `bus_cs_n` is 0 and `bus_cs` is 1 on the same clock edge as `bus_start_n` is 0. A strobe under any other select combination produces no acknowledge, no burst-inhibit, no data-enable and no register change.
- R2: A strobe accepted at the edge ending cycle N drives `bus_ack_n` to 0 for cycle N+1 only. It is 1 again in cycle N+2.
- R3: `bus_bi_n` is 0 in exactly the cycles in which `bus_ack_n` is 0.
- R4: On a write (`bus_rnw` = 0), the byte on `bus_wdata` is captured at the accepting edge into register `bus_addr`. A later read of that address returns it.
- R5: On a read (`bus_rnw` = 1), `bus_rdata` carries the addressed byte and `bus_rd_oe` is 1 during the acknowledge cycle. Outside a read's acknowledge cycle, `bus_rd_oe` is 0 and `bus_rdata` is 0.
- R6: A strobe seen during the acknowledge cycle is ignored. If the strobe is held low continuously, acknowledges therefore occur every second cycle.
- R7: `irq_n` equals the inverse of `usr_irq` delayed by one clock. It stays 0 for as long as the request is held and returns to 1 only after the request drops.
- R8: Address 31 is a read-only status byte. Bit 0 is the registered interrupt request and bits 7:1 are 0. Writes to address 31 are acknowledged but change nothing and raise no `usr_we`.
- R9: For each accepted write to addresses 0..30, `usr_we` is 1 in the acknowledge cycle, with `usr_waddr` and `usr_wdata` equal to the bus address and data. `usr_rdata` returns the register at `usr_raddr` one clock after the address is applied.
- R10: During and right after synchronous reset, `bus_ack_n`, `bus_bi_n` and `irq_n` are 1, and `bus_rd_oe` and `usr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_cs | input | 1 | Active-high chip select |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_start_n | input | 1 | Active-low transfer-start strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data from master |
| bus_rdata | output | 8 | Read data to master, 0 when not enabled |
| bus_rd_oe | output | 1 | Read data-enable (drive the bus) |
| bus_ack_n | output | 1 | Active-low transfer acknowledge |
| bus_bi_n | output | 1 | Active-low burst-inhibit |
| irq_n | output | 1 | Active-low interrupt to master |
| usr_irq | input | 1 | Level interrupt request from user logic |
| usr_we | output | 1 | Write strobe to user logic |
| usr_waddr | output | 5 | Address of the write |
| usr_wdata | output | 8 | Data of the write |
| usr_raddr | input | 5 | User read address |
| usr_rdata | output | 8 | User read data, one clock latency |

## Verification
Some properties are checked on every cycle. The acknowledge never lasts two cycles and is always matched by burst-inhibit. A selected strobe while idle always yields an acknowledge, and an unselected one never does. The data-enable and user write strobe appear only inside an acknowledge, and no user write ever targets the status address. The interrupt pin tracks the request with a one-clock delay. The bench's sweeps check the stored contents themselves: every register written with two patterns, read back over the bus and the user port, protected against stray strobes and against writes to the status byte. They also cover the status bit under both interrupt levels and the alternating acknowledge pattern under a held strobe.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } ctl_state_e;

  function automatic logic sel_ok(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              rnw,
  input  logic              start_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc,
  output logic              acc_rd,
  output logic              ack_n,
  output logic              bi_n,
  output logic              rd_phase,
  output logic              we_q,
  output logic [ADDR_W-1:0] waddr_q,
  output logic [DATA_W-1:0] wdata_q
);
  import sbus_pkg::*;

  localparam logic [ADDR_W-1:0] STAT_ADDR = {ADDR_W{1'b1}};

  ctl_state_e state;

  always_comb begin
    acc    = (state == ST_IDLE) && !start_n && sel_ok(cs_n, cs);
    acc_rd = acc && rnw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_n    <= 1'b1;
      bi_n     <= 1'b1;
      rd_phase <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (acc) begin
        state    <= ST_ACK;
        ack_n    <= 1'b0;
        bi_n     <= 1'b0;
        rd_phase <= rnw;
        if (!rnw && addr != STAT_ADDR) begin
          we_q    <= 1'b1;
          waddr_q <= addr;
          wdata_q <= wdata;
        end
      end else begin
        state    <= ST_IDLE;
        ack_n    <= 1'b1;
        bi_n     <= 1'b1;
        rd_phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_data,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    a_data <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_data <= mem[b_addr];
  end
endmodule

// File: rtl/sbus_irq.sv
module sbus_irq (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic req_q,
  output logic pin_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pin_n <= 1'b1;
    end else begin
      req_q <= req;
      pin_n <= !req;
    end
  end
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_cs,
  input  logic              bus_rnw,
  input  logic              bus_start_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_oe,
  output logic              bus_ack_n,
  output logic              bus_bi_n,
  output logic              irq_n,
  input  logic              usr_irq,
  output logic              usr_we,
  output logic [ADDR_W-1:0] usr_waddr,
  output logic [DATA_W-1:0] usr_wdata,
  input  logic [ADDR_W-1:0] usr_raddr,
  output logic [DATA_W-1:0] usr_rdata
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = {ADDR_W{1'b1}};

  logic              acc, acc_rd, rd_phase, irq_q;
  logic [DATA_W-1:0] mem_rdata;
  logic              stat_sel_q;
  logic [DATA_W-1:0] stat_q;

  sbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .cs(bus_cs), .rnw(bus_rnw),
    .start_n(bus_start_n), .addr(bus_addr), .wdata(bus_wdata),
    .acc(acc), .acc_rd(acc_rd), .ack_n(bus_ack_n), .bi_n(bus_bi_n),
    .rd_phase(rd_phase), .we_q(usr_we), .waddr_q(usr_waddr), .wdata_q(usr_wdata)
  );

  // Memory write uses the bus inputs at the accepting edge.
  logic mem_we;
  assign mem_we = acc && !bus_rnw && (bus_addr != STAT_ADDR);

  sbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .we(mem_we), .waddr(bus_addr), .wdata(bus_wdata),
    .a_addr(bus_addr), .a_data(mem_rdata),
    .b_addr(usr_raddr), .b_data(usr_rdata)
  );

  sbus_irq u_irq (
    .clk(clk), .rst(rst), .req(usr_irq), .req_q(irq_q), .pin_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_sel_q <= 1'b0;
      stat_q     <= '0;
    end else if (acc_rd) begin
      stat_sel_q <= (bus_addr == STAT_ADDR);
      stat_q     <= {{(DATA_W-1){1'b0}}, irq_q};
    end
  end

  assign bus_rd_oe = rd_phase;
  assign bus_rdata = !rd_phase ? '0 : (stat_sel_q ? stat_q : mem_rdata);
endmodule

// File: rtl/sbus_slave_chk.sv
module sbus_slave_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_cs,
  input logic              bus_start_n,
  input logic              bus_rd_oe,
  input logic              bus_ack_n,
  input logic              bus_bi_n,
  input logic              irq_n,
  input logic              usr_irq,
  input logic              usr_we,
  input logic [ADDR_W-1:0] usr_waddr
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = {ADDR_W{1'b1}};

  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !bus_ack_n |=> bus_ack_n);

  a_r2_ack_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_n && !bus_start_n && !bus_cs_n && bus_cs) |=> !bus_ack_n);

  a_r1_unselected_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_n && !(!bus_cs_n && bus_cs)) |=> bus_ack_n);

  a_r3_bi_with_ack: assert property (@(posedge clk) disable iff (rst)
    bus_bi_n == bus_ack_n);

  a_r5_oe_in_ack: assert property (@(posedge clk) disable iff (rst)
    bus_rd_oe |-> !bus_ack_n);

  a_r9_we_in_ack: assert property (@(posedge clk) disable iff (rst)
    usr_we |-> (!bus_ack_n && !bus_rd_oe));

  a_r8_no_status_write: assert property (@(posedge clk) disable iff (rst)
    usr_we |-> usr_waddr != STAT_ADDR);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_n == !$past(usr_irq));
endmodule

bind sbus_slave sbus_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_cs(bus_cs),
  .bus_start_n(bus_start_n), .bus_rd_oe(bus_rd_oe), .bus_ack_n(bus_ack_n),
  .bus_bi_n(bus_bi_n), .irq_n(irq_n), .usr_irq(usr_irq), .usr_we(usr_we),
  .usr_waddr(usr_waddr)
);

// File: tb/sbus_slave_bench.sv
module sbus_slave_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_cs = 1'b0, bus_rnw = 1'b1, bus_start_n = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rd_oe, bus_ack_n, bus_bi_n, irq_n;
  logic       usr_irq = 1'b0;
  logic       usr_we;
  logic [4:0] usr_waddr;
  logic [7:0] usr_wdata;
  logic [4:0] usr_raddr = '0;
  logic [7:0] usr_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Captured results of the last transfer
  logic       c_ack, c_bi, c_oe, c_we, c_ack2, c_oe2, c_we2;
  logic [7:0] c_rd, c_rd2, c_wd;
  logic [4:0] c_wa;

  always #2 clk = ~clk;

  sbus_slave u_sbus_slave (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_cs(bus_cs),
    .bus_rnw(bus_rnw), .bus_start_n(bus_start_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_oe(bus_rd_oe),
    .bus_ack_n(bus_ack_n), .bus_bi_n(bus_bi_n), .irq_n(irq_n),
    .usr_irq(usr_irq), .usr_we(usr_we), .usr_waddr(usr_waddr),
    .usr_wdata(usr_wdata), .usr_raddr(usr_raddr), .usr_rdata(usr_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    logic [7:0] v = 8'((a * 37 + 5) & 8'hFF);
    return (k == 0) ? v : (~v ^ 8'(a));
  endfunction

  // One transfer: strobe low for one cycle, capture ack cycle and following cycle.
  task automatic xfer(input logic rnw, input logic [4:0] a, input logic [7:0] d,
                      input logic csn, input logic cs);
    @(negedge clk);
    bus_rnw = rnw; bus_addr = a; bus_wdata = d; bus_cs_n = csn; bus_cs = cs;
    bus_start_n = 1'b0;
    @(negedge clk);
    bus_start_n = 1'b1; bus_wdata = ~d;
    c_ack = bus_ack_n; c_bi = bus_bi_n; c_oe = bus_rd_oe; c_rd = bus_rdata;
    c_we = usr_we; c_wa = usr_waddr; c_wd = usr_wdata;
    @(negedge clk);
    c_ack2 = bus_ack_n; c_oe2 = bus_rd_oe; c_rd2 = bus_rdata; c_we2 = usr_we;
    bus_cs_n = 1'b1; bus_cs = 1'b0;
  endtask

  task automatic sel_read(input logic [4:0] a, input logic [7:0] exp, input string req);
    xfer(1'b1, a, 8'h00, 1'b0, 1'b1);
    chk(c_ack == 1'b0 && c_ack2 == 1'b1, "R2 ack one cycle", {c_ack, c_ack2}, 2'b01);
    chk(c_bi == 1'b0, "R3 bi with ack", c_bi, 0);
    chk(c_oe == 1'b1 && c_oe2 == 1'b0, "R5 oe in ack only", {c_oe, c_oe2}, 2'b10);
    chk(c_rd == exp, req, c_rd, exp);
    chk(c_rd2 == 8'h00, "R5 rdata zero outside ack", c_rd2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bus_ack_n && bus_bi_n && irq_n && !bus_rd_oe && !usr_we, "R10 reset outputs",
        {bus_ack_n, bus_bi_n, irq_n, bus_rd_oe, usr_we}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ack_n && bus_bi_n && irq_n && !bus_rd_oe && !usr_we, "R10 after reset",
        {bus_ack_n, bus_bi_n, irq_n, bus_rd_oe, usr_we}, 5'b11100);

    for (int k = 0; k < 2; k++) begin
      // R4 / R9 write sweep over every data register
      for (int a = 0; a < 31; a++) begin
        xfer(1'b0, 5'(a), pat(a, k), 1'b0, 1'b1);
        chk(c_ack == 1'b0 && c_ack2 == 1'b1, "R2 write ack", {c_ack, c_ack2}, 2'b01);
        chk(c_bi == 1'b0, "R3 write bi", c_bi, 0);
        chk(c_oe == 1'b0, "R5 no oe on write", c_oe, 0);
        chk(c_we && !c_we2 && c_wa == 5'(a) && c_wd == pat(a, k), "R9 user write strobe",
            {c_we, c_wa, c_wd}, {1'b1, 5'(a), pat(a, k)});
      end
      // R4 bus readback and R9 user readback
      for (int a = 0; a < 31; a++) begin
        sel_read(5'(a), pat(a, k), "R4 bus readback");
        @(negedge clk); usr_raddr = 5'(a);
        @(negedge clk);
        chk(usr_rdata == pat(a, k), "R9 user readback", usr_rdata, pat(a, k));
      end
    end

    // R1 unselected strobes: three wrong select combinations, reads and writes
    for (int c = 0; c < 3; c++) begin
      for (int a = 0; a < 31; a += 5) begin
        logic csn, cs;
        csn = (c == 1) ? 1'b0 : 1'b1;
        cs  = (c == 2) ? 1'b1 : ((c == 0) ? 1'b1 : 1'b0);
        if (c == 0) begin csn = 1'b1; cs = 1'b1; end
        if (c == 1) begin csn = 1'b0; cs = 1'b0; end
        if (c == 2) begin csn = 1'b1; cs = 1'b0; end
        xfer(1'b0, 5'(a), 8'hA5, csn, cs);
        chk(c_ack && c_bi && c_ack2 && !c_we, "R1 unselected write ignored",
            {c_ack, c_bi, c_ack2, c_we}, 4'b1110);
        xfer(1'b1, 5'(a), 8'h00, csn, cs);
        chk(c_ack && !c_oe && c_rd == 8'h00, "R1 unselected read ignored",
            {c_ack, c_oe, c_rd}, {1'b1, 1'b0, 8'h00});
        sel_read(5'(a), pat(a, 1), "R1 contents unchanged");
      end
    end

    // R8 status byte with interrupt low and high
    sel_read(5'd31, 8'h00, "R8 status irq=0");
    @(negedge clk); usr_irq = 1'b1;
    @(negedge clk);
    chk(irq_n == 1'b0, "R7 irq pin asserted", irq_n, 0);
    sel_read(5'd31, 8'h01, "R8 status irq=1");
    xfer(1'b0, 5'd31, 8'hFE, 1'b0, 1'b1);
    chk(c_ack == 1'b0 && !c_we, "R8 status write acked, no user write", {c_ack, c_we}, 2'b00);
    sel_read(5'd31, 8'h01, "R8 status after write");
    repeat (20) @(negedge clk);
    chk(irq_n == 1'b0, "R7 irq held", irq_n, 0);
    usr_irq = 1'b0;
    @(negedge clk);
    chk(irq_n == 1'b1, "R7 irq released", irq_n, 1);
    sel_read(5'd31, 8'h00, "R8 status cleared");
    sel_read(5'd30, pat(30, 1), "R8 neighbour intact");

    // R6 strobe held low: ack every second cycle
    @(negedge clk);
    bus_rnw = 1'b1; bus_addr = 5'd3; bus_cs_n = 1'b0; bus_cs = 1'b1; bus_start_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bus_ack_n == logic'(i % 2), "R6 alternating ack", bus_ack_n, i % 2);
    end
    bus_start_n = 1'b1; bus_cs_n = 1'b1; bus_cs = 1'b0;
    @(negedge clk);
    chk(bus_ack_n == 1'b1, "R6 idle after strobe", bus_ack_n, 1);

    finish_run();
  end
endmodule